// File: doc/BRIEF.md
# DMA Channel Interrupt Status Block

This block keeps two interrupt flags per DMA channel, one for terminal count and one for error. The transfer engine sets them with single-cycle pulses. Software reads them through a small word-addressed register port and clears them there. The block has no mask registers of its own. Each channel's interrupt enables come straight from two bits of that channel's configuration word, which another part of the controller holds and presents on the `ch_cfg` bus. The same bus supplies each channel's enable bit, and the block reports those bits as a bitmap.

Status can be read in two ways. The raw view shows every flag. The masked view shows only the flags whose enable is set. One level-sensitive interrupt output combines the masked terminal-count and masked error flags of all channels. The channel count is a parameter and must be 8 or 2. Register reads are combinational from the current state. Writes take effect at the next rising clock edge.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset all terminal-count and error flags are zero, `irq` is low, and raw status reads (word offsets 5 and 6) return zero.
- R2: A pulse on `tc_set[c]` or `err_set[c]` sets flag c of that kind at the next rising edge. Word 5 returns the raw terminal-count flags and word 6 the raw error flags, with channel c at data bit c.
- R3: The terminal-count enable of channel c is bit 15 of its configuration word, and the error enable is bit 14. Word 1 returns terminal-count flags AND their enables. Word 3 returns error flags AND their enables.
- R4: Word 0 returns the bitwise OR of the masked terminal-count and masked error status.
- R5: A write to word 2 clears every terminal-count flag whose write-data bit is 1. A write to word 4 does the same for the error flags. Flags whose data bit is 0 keep their value.
- R6: When a set pulse and a clear write hit the same flag in the same cycle, the flag ends up set.
- R7: `irq` is high exactly when at least one channel has a flag that is both set and enabled, of either kind.
- R8: Word 7 returns a bitmap with bit c equal to bit 0 (enable) of channel c's configuration word.
- R9: Reads of words 2 and 4 and of any offset above 7 return zero. A write to any offset other than 2 or 4 leaves all flags unchanged.
- R10: Read-data bits at and above the channel count are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_off | input | OFF_W | Word offset of the register access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_off`, combinational |
| tc_set | input | NUM_CH | Per-channel terminal-count set pulses |
| err_set | input | NUM_CH | Per-channel error set pulses |
| ch_cfg | input | NUM_CH*CFG_W | Configuration words, channel c at bits [c*CFG_W +: CFG_W] |
| irq | output | 1 | Combined masked interrupt |

## Verification
A flag stuck, lost or wrongly cleared shows up in the raw reads of words 5 and 6 in the cycle after the pulse or write that should have changed it. If the enable is set, it also shows on `irq` in that same cycle. A wrong tap on the configuration word leaves the raw reads correct but changes the masked words 0, 1 and 3 and `irq` at once, with no clock edge needed, because masks and reads are combinational. Decode faults appear as nonzero data on write-only or undefined offsets, or as flags that change after writes to read-only words.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

   // configuration word bit positions consumed by this block
   localparam int unsigned CFG_BIT_TC_IE  = 15;
   localparam int unsigned CFG_BIT_ERR_IE = 14;
   localparam int unsigned CFG_BIT_CH_EN  = 0;

   // register word offsets
   localparam int unsigned WOFF_MASKED_ALL = 0;
   localparam int unsigned WOFF_MASKED_TC  = 1;
   localparam int unsigned WOFF_CLEAR_TC   = 2;
   localparam int unsigned WOFF_MASKED_ERR = 3;
   localparam int unsigned WOFF_CLEAR_ERR  = 4;
   localparam int unsigned WOFF_RAW_TC     = 5;
   localparam int unsigned WOFF_RAW_ERR    = 6;
   localparam int unsigned WOFF_EN_MAP     = 7;

   typedef enum logic [2:0] {
      RSEL_NONE,
      RSEL_ALL,
      RSEL_TC,
      RSEL_ERR,
      RSEL_RAW_TC,
      RSEL_RAW_ERR,
      RSEL_EN_MAP
   } rsel_e;

endpackage

// File: rtl/dma_irq_cfg_tap.sv
module dma_irq_cfg_tap #(
   parameter int unsigned NUM_CH  = 8,
   parameter int unsigned CFG_W   = 32,
   parameter int unsigned TC_BIT  = 15,
   parameter int unsigned ERR_BIT = 14,
   parameter int unsigned EN_BIT  = 0
) (
   input  logic [NUM_CH*CFG_W-1:0] ch_cfg,
   output logic [NUM_CH-1:0]       tc_mask,
   output logic [NUM_CH-1:0]       err_mask,
   output logic [NUM_CH-1:0]       ch_en
);

   if (TC_BIT >= CFG_W || ERR_BIT >= CFG_W || EN_BIT >= CFG_W) begin : g_bad_bits
      $error("dma_irq_cfg_tap: tap bit outside configuration word");
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam int unsigned BASE = c * CFG_W;
      assign tc_mask[c]  = ch_cfg[BASE + TC_BIT];
      assign err_mask[c] = ch_cfg[BASE + ERR_BIT];
      assign ch_en[c]    = ch_cfg[BASE + EN_BIT];
   end

   logic unused_cfg_bits;
   assign unused_cfg_bits = ^ch_cfg;

endmodule

// File: rtl/dma_irq_flag_bank.sv
module dma_irq_flag_bank #(
   parameter int unsigned NUM_CH   = 8,
   parameter bit          SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] set_pulse,
   input  logic [NUM_CH-1:0] clr_bits,
   output logic [NUM_CH-1:0] flags
);

   logic [NUM_CH-1:0] flags_nxt;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_flag
      if (SET_WINS) begin : g_set_first
         assign flags_nxt[c] = set_pulse[c] | (flags[c] & ~clr_bits[c]);
      end else begin : g_clr_first
         assign flags_nxt[c] = (flags[c] | set_pulse[c]) & ~clr_bits[c];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flags[c] <= 1'b0;
         end else begin
            flags[c] <= flags_nxt[c];
         end
      end
   end

endmodule

// File: rtl/dma_irq_reg_decode.sv
module dma_irq_reg_decode
   import dma_irq_pkg::*;
#(
   parameter int unsigned OFF_W = 8
) (
   input  logic             reg_wr,
   input  logic [OFF_W-1:0] reg_off,
   output rsel_e            rsel,
   output logic             clr_tc_en,
   output logic             clr_err_en
);

   if (OFF_W < 3) begin : g_bad_off
      $error("dma_irq_reg_decode: OFF_W must cover eight words");
   end

   always_comb begin
      rsel = RSEL_NONE;
      if (reg_off == OFF_W'(WOFF_MASKED_ALL)) rsel = RSEL_ALL;
      if (reg_off == OFF_W'(WOFF_MASKED_TC))  rsel = RSEL_TC;
      if (reg_off == OFF_W'(WOFF_MASKED_ERR)) rsel = RSEL_ERR;
      if (reg_off == OFF_W'(WOFF_RAW_TC))     rsel = RSEL_RAW_TC;
      if (reg_off == OFF_W'(WOFF_RAW_ERR))    rsel = RSEL_RAW_ERR;
      if (reg_off == OFF_W'(WOFF_EN_MAP))     rsel = RSEL_EN_MAP;
   end

   assign clr_tc_en  = reg_wr && (reg_off == OFF_W'(WOFF_CLEAR_TC));
   assign clr_err_en = reg_wr && (reg_off == OFF_W'(WOFF_CLEAR_ERR));

endmodule

// File: rtl/dma_irq_rd_mux.sv
module dma_irq_rd_mux
   import dma_irq_pkg::*;
#(
   parameter int unsigned NUM_CH = 8,
   parameter int unsigned DATA_W = 32
) (
   input  rsel_e             rsel,
   input  logic [NUM_CH-1:0] tc_masked,
   input  logic [NUM_CH-1:0] err_masked,
   input  logic [NUM_CH-1:0] tc_raw,
   input  logic [NUM_CH-1:0] err_raw,
   input  logic [NUM_CH-1:0] ch_en,
   output logic [DATA_W-1:0] rdata
);

   logic [NUM_CH-1:0] pick;

   always_comb begin
      unique case (rsel)
         RSEL_ALL:     pick = tc_masked | err_masked;
         RSEL_TC:      pick = tc_masked;
         RSEL_ERR:     pick = err_masked;
         RSEL_RAW_TC:  pick = tc_raw;
         RSEL_RAW_ERR: pick = err_raw;
         RSEL_EN_MAP:  pick = ch_en;
         default:      pick = '0;
      endcase
   end

   if (DATA_W > NUM_CH) begin : g_pad
      assign rdata = {{(DATA_W-NUM_CH){1'b0}}, pick};
   end else begin : g_exact
      assign rdata = pick;
   end

endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
   import dma_irq_pkg::*;
#(
   parameter int unsigned NUM_CH   = 8,
   parameter int unsigned CFG_W    = 32,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned OFF_W    = 8,
   parameter bit          SET_WINS = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    reg_wr,
   input  logic [OFF_W-1:0]        reg_off,
   input  logic [DATA_W-1:0]       reg_wdata,
   output logic [DATA_W-1:0]       reg_rdata,
   input  logic [NUM_CH-1:0]       tc_set,
   input  logic [NUM_CH-1:0]       err_set,
   input  logic [NUM_CH*CFG_W-1:0] ch_cfg,
   output logic                    irq
);

   if (!(NUM_CH == 8 || NUM_CH == 2)) begin : g_bad_ch
      $error("dma_irq_ctrl: NUM_CH must be 8 or 2");
   end
   if (DATA_W < NUM_CH) begin : g_bad_data
      $error("dma_irq_ctrl: DATA_W narrower than channel count");
   end

   logic [NUM_CH-1:0] tc_mask, err_mask, ch_en;
   logic [NUM_CH-1:0] tc_flags, err_flags;
   logic [NUM_CH-1:0] tc_clr, err_clr;
   logic [NUM_CH-1:0] tc_masked, err_masked;
   logic              clr_tc_en, clr_err_en;
   rsel_e             rsel;

   dma_irq_cfg_tap #(
      .NUM_CH (NUM_CH),
      .CFG_W  (CFG_W),
      .TC_BIT (CFG_BIT_TC_IE),
      .ERR_BIT(CFG_BIT_ERR_IE),
      .EN_BIT (CFG_BIT_CH_EN)
   ) u_cfg_tap (
      .ch_cfg  (ch_cfg),
      .tc_mask (tc_mask),
      .err_mask(err_mask),
      .ch_en   (ch_en)
   );

   dma_irq_reg_decode #(
      .OFF_W(OFF_W)
   ) u_decode (
      .reg_wr    (reg_wr),
      .reg_off   (reg_off),
      .rsel      (rsel),
      .clr_tc_en (clr_tc_en),
      .clr_err_en(clr_err_en)
   );

   assign tc_clr  = clr_tc_en  ? reg_wdata[NUM_CH-1:0] : '0;
   assign err_clr = clr_err_en ? reg_wdata[NUM_CH-1:0] : '0;

   dma_irq_flag_bank #(
      .NUM_CH  (NUM_CH),
      .SET_WINS(SET_WINS)
   ) u_tc_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_pulse(tc_set),
      .clr_bits (tc_clr),
      .flags    (tc_flags)
   );

   dma_irq_flag_bank #(
      .NUM_CH  (NUM_CH),
      .SET_WINS(SET_WINS)
   ) u_err_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_pulse(err_set),
      .clr_bits (err_clr),
      .flags    (err_flags)
   );

   assign tc_masked  = tc_flags & tc_mask;
   assign err_masked = err_flags & err_mask;
   assign irq        = |(tc_masked | err_masked);

   dma_irq_rd_mux #(
      .NUM_CH(NUM_CH),
      .DATA_W(DATA_W)
   ) u_rd_mux (
      .rsel      (rsel),
      .tc_masked (tc_masked),
      .err_masked(err_masked),
      .tc_raw    (tc_flags),
      .err_raw   (err_flags),
      .ch_en     (ch_en),
      .rdata     (reg_rdata)
   );

   logic unused_wdata;
   assign unused_wdata = ^reg_wdata;

endmodule

// File: rtl/dma_irq_ctrl_chk.sv
module dma_irq_ctrl_chk #(
   parameter int unsigned NUM_CH = 8,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned OFF_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [OFF_W-1:0]  reg_off,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic [NUM_CH-1:0] tc_set,
   input logic [NUM_CH-1:0] err_set,
   input logic [NUM_CH-1:0] tc_flags,
   input logic [NUM_CH-1:0] err_flags,
   input logic              irq
);

   logic wr_clr_tc, wr_clr_err;
   assign wr_clr_tc  = reg_wr && (reg_off == OFF_W'(2));
   assign wr_clr_err = reg_wr && (reg_off == OFF_W'(4));

   // R2: every pulsed flag is set one cycle later
   assert_tc_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (|tc_set) |=> ((tc_flags & $past(tc_set)) == $past(tc_set)));

   assert_err_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (|err_set) |=> ((err_flags & $past(err_set)) == $past(err_set)));

   // R5: a clear write drops the addressed flags not pulsed in that cycle
   assert_tc_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr_tc |=> ((tc_flags & $past(reg_wdata[NUM_CH-1:0]) & ~$past(tc_set)) == '0));

   assert_err_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr_err |=> ((err_flags & $past(reg_wdata[NUM_CH-1:0]) & ~$past(err_set)) == '0));

   // R6: set beats clear on the same flag
   assert_set_beats_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clr_tc && |(tc_set & reg_wdata[NUM_CH-1:0]))
         |=> ((tc_flags & $past(tc_set)) == $past(tc_set)));

   // R9: without a pulse or a matching clear write, flags do not change
   assert_tc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_clr_tc && tc_set == '0) |=> $stable(tc_flags));

   assert_err_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_clr_err && err_set == '0) |=> $stable(err_flags));

   // R9: write-only and undefined words read as zero
   assert_undef_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_off == OFF_W'(2) || reg_off == OFF_W'(4) || reg_off > OFF_W'(7))
         |-> (reg_rdata == '0));

   // R7: no flags means no interrupt
   assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_flags == '0 && err_flags == '0) |-> !irq);

endmodule

bind dma_irq_ctrl dma_irq_ctrl_chk #(
   .NUM_CH(NUM_CH),
   .DATA_W(DATA_W),
   .OFF_W (OFF_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_wr   (reg_wr),
   .reg_off  (reg_off),
   .reg_wdata(reg_wdata),
   .reg_rdata(reg_rdata),
   .tc_set   (tc_set),
   .err_set  (err_set),
   .tc_flags (tc_flags),
   .err_flags(err_flags),
   .irq      (irq)
);

// File: tb/test_dma_irq_ctrl.sv
`timescale 1ns/1ps
module test_dma_irq_ctrl;

   localparam int NCH = 8;
   localparam int CW  = 32;
   localparam int DW  = 32;
   localparam int OW  = 8;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               reg_wr = 1'b0;
   logic [OW-1:0]      reg_off = '0;
   logic [DW-1:0]      reg_wdata = '0;
   logic [DW-1:0]      reg_rdata;
   logic [NCH-1:0]     tc_set = '0;
   logic [NCH-1:0]     err_set = '0;
   logic [NCH*CW-1:0]  ch_cfg = '0;
   logic               irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [NCH-1:0] m_tc = '0;
   logic [NCH-1:0] m_err = '0;

   always #5 clk = ~clk;

   dma_irq_ctrl #(
      .NUM_CH(NCH), .CFG_W(CW), .DATA_W(DW), .OFF_W(OW)
   ) i_dma_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_off(reg_off),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tc_set(tc_set),
      .err_set(err_set), .ch_cfg(ch_cfg), .irq(irq)
   );

   function automatic logic [NCH-1:0] cfg_bits(input logic [NCH*CW-1:0] c, input int pos);
      logic [NCH-1:0] r;
      for (int i = 0; i < NCH; i++) r[i] = c[i*CW + pos];
      return r;
   endfunction

   function automatic logic [DW-1:0] exp_read(input int off);
      logic [NCH-1:0] mt, me;
      mt = m_tc & cfg_bits(ch_cfg, 15);
      me = m_err & cfg_bits(ch_cfg, 14);
      case (off)
         0: return DW'(mt | me);
         1: return DW'(mt);
         3: return DW'(me);
         5: return DW'(m_tc);
         6: return DW'(m_err);
         7: return DW'(cfg_bits(ch_cfg, 0));
         default: return '0;
      endcase
   endfunction

   function automatic logic exp_irq();
      return |((m_tc & cfg_bits(ch_cfg, 15)) | (m_err & cfg_bits(ch_cfg, 14)));
   endfunction

   function automatic string tag_of(input int off);
      case (off)
         0: return "R4";
         1, 3: return "R3";
         5, 6: return "R2";
         7: return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one clocked cycle with stimulus; the model follows at the edge
   task automatic step(input logic [NCH-1:0] ts, input logic [NCH-1:0] es,
                       input logic wr, input int off, input logic [DW-1:0] wd);
      logic [NCH-1:0] ctc, cerr;
      @(negedge clk);
      tc_set = ts; err_set = es; reg_wr = wr; reg_off = OW'(off); reg_wdata = wd;
      @(posedge clk);
      ctc  = (wr && off == 2) ? wd[NCH-1:0] : '0;
      cerr = (wr && off == 4) ? wd[NCH-1:0] : '0;
      m_tc  = (m_tc & ~ctc) | ts;
      m_err = (m_err & ~cerr) | es;
   endtask

   task automatic rd(input int off, input string req);
      @(negedge clk);
      tc_set = '0; err_set = '0; reg_wr = 1'b0; reg_off = OW'(off);
      #1;
      chk(reg_rdata, exp_read(off), req);
   endtask

   task automatic rd_all();
      for (int o = 0; o < 8; o++) rd(o, tag_of(o));
      chk(DW'(irq), DW'(exp_irq()), "R7");
      // R10: bits above the channel count stay zero
      chk(DW'(reg_rdata[DW-1:NCH]), '0, "R10");
   endtask

   initial begin
      #(200_000 * 10);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      rd(5, "R1");
      rd(6, "R1");
      chk(DW'(irq), '0, "R1");

      // R2/R3/R7: flag raised with enables off is raw-only
      ch_cfg = '0;
      step(8'h08, 8'h00, 1'b0, 0, '0);
      rd(5, "R2");
      rd(1, "R3");
      chk(DW'(irq), '0, "R7 masked off");
      ch_cfg[3*CW + 15] = 1'b1;
      rd(1, "R3");
      rd(0, "R4");
      chk(DW'(irq), 32'd1, "R7 masked on");

      // R6: set and clear of channel 3 in one cycle
      step(8'h08, 8'h00, 1'b1, 2, 32'h0000_0008);
      rd(5, "R6");
      // R5: plain clear
      step(8'h00, 8'h00, 1'b1, 2, 32'hFFFF_FFFF);
      rd(5, "R5");
      chk(DW'(irq), '0, "R5 irq");

      // R9: writes to read-only and undefined words change nothing
      step(8'hA5, 8'h3C, 1'b0, 0, '0);
      step(8'h00, 8'h00, 1'b1, 5, 32'hFFFF_FFFF);
      step(8'h00, 8'h00, 1'b1, 12, 32'hFFFF_FFFF);
      step(8'h00, 8'h00, 1'b1, 0, 32'hFFFF_FFFF);
      rd(5, "R9");
      rd(6, "R9");
      rd(200, "R9");
      rd(2, "R9");
      rd(4, "R9");

      // R5: error clear only hits error flags with data bit 1
      step(8'h00, 8'h00, 1'b1, 4, 32'h0000_000C);
      rd(6, "R5");
      rd(5, "R5");

      // R8: enable bitmap
      ch_cfg = '0;
      ch_cfg[0*CW] = 1'b1; ch_cfg[6*CW] = 1'b1; ch_cfg[7*CW] = 1'b1;
      rd(7, "R8");

      // constrained random mix
      for (int it = 0; it < 600; it++) begin
         logic [NCH-1:0] ts, es;
         int off;
         logic wr;
         if ((it % 16) == 0) begin
            for (int c = 0; c < NCH; c++) ch_cfg[c*CW +: CW] = $urandom();
         end
         ts = NCH'($urandom() & $urandom());
         es = NCH'($urandom() & $urandom());
         wr = 1'($urandom());
         case ($urandom() % 4)
            0: off = 2;
            1: off = 4;
            default: off = int'($urandom() % 16);
         endcase
         step(ts, es, wr, off, $urandom());
         if ((it % 4) == 0) rd_all();
      end
      rd_all();

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule